// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Router

This block collects level-sensitive interrupt lines from devices and forwards them to up to four processors. A source passes two gates before it reaches a processor. The first gate is a global enable bit per source. The second gate depends on the source's class. Low-numbered sources, 0 through a configurable boundary (28 by default), are private to each processor and pass through that processor's own mask bit. Higher sources are shared and pass through a routing field that names the processors allowed to take them. Sources 0 and 1 are conventionally wired to the summary lines of the inter-processor and message-signalled doorbell logic, which sit outside this block.

Software reaches the block over a simple register bus with two windows. The global window holds a read-only control word giving the number of implemented sources, set-enable and clear-enable registers that take a source number, and one routing register per source. The per-processor window is banked by a processor-id input. In it, a processor masks or unmasks a private source by writing its number, and reads an acknowledge register that returns the lowest-numbered source currently pending for it. Enables and masks change by writing an index, so no read-modify-write of a bitmap is ever needed.

Each processor has one interrupt output, driven from a register, that is high while at least one source is pending, enabled and open for that processor. Because sources are level-sensitive, reading the acknowledge register changes nothing; a source stays pending until its line drops.

Top module: `irq_router_2lvl`

## Requirements
- R1: A read takes effect one cycle later: bus_rvalid is high in the cycle after bus_rd and bus_rdata holds the value; a global-window read at offset 0x000 returns the number of sources in bits [11:2] with all other bits 0.
- R2: After reset every cpu_irq bit is 0, every global enable is 0, every per-processor mask bit is 1 and every routing field is 0, so no line reaches any processor.
- R3: Writing a source number to global offset 0x030 enables that source; writing it to global offset 0x034 disables it; a number not below the source count changes nothing.
- R4: The routing register of source i sits at global offset 0x100 + 4*i; bit c of it (bits [3:0] for four processors) permits processor c to take a shared source, and it reads back as written.
- R5: In the per-processor window, writing a source number to offset 0x048 sets the mask bit of the processor given by bus_cpu and writing it to offset 0x04C clears it; other processors' mask bits are untouched.
- R6: A private source (number 0 to 28) is pending for processor c when its line is high, it is enabled and c's mask bit for it is clear; its routing field has no effect.
- R7: A shared source (number 29 and up) is pending for processor c when its line is high, it is enabled and bit c of its routing field is 1; the per-processor mask bits have no effect on it.
- R8: cpu_irq[c] is a register output: it reflects the pending state one clock edge after that state changes.
- R9: A per-processor read at offset 0x044 returns in bits [9:0] the lowest-numbered source pending for bus_cpu, or 1023 when none is pending, with bits [31:10] zero; the read has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NUM_SRC (64) | Level-sensitive source lines, bit i is source i |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_win | input | 1 | Window select: 0 global, 1 per-processor |
| bus_cpu | input | CPU_W (2) | Processor id selecting the per-processor bank |
| bus_addr | input | ADDR_W (12) | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |
| cpu_irq | output | NUM_CPU (4) | Registered interrupt request per processor |

## Verification
The bound checker watches on every cycle that read data follows its strobe by one cycle, that the control word always carries the source count, that all outputs fall quiet one edge after every line is low, and that any acknowledge value is either 1023 or the number of a source whose line was high when the read was taken. What it cannot see is whether the two gates are applied to the right class of source: the private/shared split, the per-processor banking of masks, index-based enable and mask writes, routing readback and the lowest-number ordering of acknowledge are shown only by the directed scenarios, including the boundary between sources 28 and 29 and an out-of-range enable index that aliases a real source in its low bits.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  // Global window offsets
  localparam int unsigned OFS_CTRL       = 32'h000;
  localparam int unsigned OFS_EN_SET     = 32'h030;
  localparam int unsigned OFS_EN_CLR     = 32'h034;
  localparam int unsigned OFS_ROUTE_BASE = 32'h100;
  // Per-processor window offsets
  localparam int unsigned OFS_ACK        = 32'h044;
  localparam int unsigned OFS_MASK_SET   = 32'h048;
  localparam int unsigned OFS_MASK_CLR   = 32'h04C;
  // Acknowledge value when nothing is pending
  localparam int unsigned ACK_NONE       = 1023;

  typedef enum logic {
    WIN_GLOBAL = 1'b0,
    WIN_CPU    = 1'b1
  } win_e;
endpackage

// File: rtl/irqr_index_bits.sv
// Bit vector changed by writing an index to a set or a clear strobe.
module irqr_index_bits #(
  parameter int N       = 64,
  parameter int DW      = 32,
  parameter bit RST_VAL = 1'b0,
  localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_stb,
  input  logic          clr_stb,
  input  logic [DW-1:0] idx,
  output logic [N-1:0]  bits
);
  logic in_range;
  assign in_range = (idx < DW'(N));

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= {N{RST_VAL}};
    end else if (in_range) begin
      if (set_stb)      bits[idx[IW-1:0]] <= 1'b1;
      else if (clr_stb) bits[idx[IW-1:0]] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqr_route_table.sv
// Per-source routing fields; all fields are visible at once for gating.
module irqr_route_table #(
  parameter int N    = 64,
  parameter int NC   = 4,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [IW-1:0]         widx,
  input  logic [NC-1:0]         wdata,
  output logic [N-1:0][NC-1:0]  route
);
  always_ff @(posedge clk) begin
    if (rst) begin
      route <= '0;
    end else if (we) begin
      route[widx] <= wdata;
    end
  end
endmodule

// File: rtl/irqr_lowest_first.sv
// Finds the lowest-numbered set bit of a vector.
module irqr_lowest_first #(
  parameter int N   = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_router_2lvl.sv
module irq_router_2lvl #(
  parameter int NUM_SRC     = 64,
  parameter int NUM_CPU     = 4,
  parameter int PERCPU_LAST = 28,
  parameter int ADDR_W      = 12,
  localparam int DW         = 32,
  localparam int IW         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_win,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_rvalid,
  output logic [NUM_CPU-1:0] cpu_irq
);
  import irqr_pkg::*;

  // ---------------- address decode ----------------
  logic wr_glb, wr_cpu;
  assign wr_glb = bus_wr && (bus_win == WIN_GLOBAL);
  assign wr_cpu = bus_wr && (bus_win == WIN_CPU);

  logic en_set, en_clr;
  assign en_set = wr_glb && (bus_addr == ADDR_W'(OFS_EN_SET));
  assign en_clr = wr_glb && (bus_addr == ADDR_W'(OFS_EN_CLR));

  logic [ADDR_W-1:0] route_off;
  logic [ADDR_W-3:0] route_sel;
  logic              route_hit;
  logic [1:0]        unused_route_lsb;
  assign route_off        = bus_addr - ADDR_W'(OFS_ROUTE_BASE);
  assign route_sel        = route_off[ADDR_W-1:2];
  assign unused_route_lsb = route_off[1:0];
  assign route_hit = (bus_addr >= ADDR_W'(OFS_ROUTE_BASE)) &&
                     (bus_addr[1:0] == 2'b00) &&
                     (route_sel < (ADDR_W-2)'(NUM_SRC));

  logic [IW-1:0] route_idx;
  assign route_idx = route_sel[IW-1:0];

  logic [DW-NUM_CPU-1:0] unused_wdata_hi;
  assign unused_wdata_hi = bus_wdata[DW-1:NUM_CPU];

  // ---------------- first gate: global enables ----------------
  logic [NUM_SRC-1:0] glb_en;
  irqr_index_bits #(.N(NUM_SRC), .DW(DW), .RST_VAL(1'b0)) u_enable (
    .clk     (clk),
    .rst     (rst),
    .set_stb (en_set),
    .clr_stb (en_clr),
    .idx     (bus_wdata),
    .bits    (glb_en)
  );

  // ---------------- routing fields for shared sources ----------------
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;
  irqr_route_table #(.N(NUM_SRC), .NC(NUM_CPU)) u_route (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_glb && route_hit),
    .widx  (route_idx),
    .wdata (bus_wdata[NUM_CPU-1:0]),
    .route (route_q)
  );

  // ---------------- per-processor masks, gating, selection ----------------
  logic [NUM_CPU-1:0][NUM_SRC-1:0] cpu_mask;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] pend;
  logic [NUM_CPU-1:0]              pend_any;
  logic [NUM_CPU-1:0][IW-1:0]      pend_low;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic bank_hit;
    assign bank_hit = wr_cpu && (bus_cpu == CPU_W'(c));

    irqr_index_bits #(.N(NUM_SRC), .DW(DW), .RST_VAL(1'b1)) u_mask (
      .clk     (clk),
      .rst     (rst),
      .set_stb (bank_hit && (bus_addr == ADDR_W'(OFS_MASK_SET))),
      .clr_stb (bank_hit && (bus_addr == ADDR_W'(OFS_MASK_CLR))),
      .idx     (bus_wdata),
      .bits    (cpu_mask[c])
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (s <= PERCPU_LAST) begin : g_private
        assign pend[c][s] = src_lvl[s] && glb_en[s] && !cpu_mask[c][s];
      end else begin : g_shared
        assign pend[c][s] = src_lvl[s] && glb_en[s] && route_q[s][c];
      end
    end

    irqr_lowest_first #(.N(NUM_SRC)) u_pick (
      .vec (pend[c]),
      .any (pend_any[c]),
      .idx (pend_low[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= '0;
    else     cpu_irq <= pend_any;
  end

  // ---------------- read path ----------------
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_win == WIN_GLOBAL) begin
      if (bus_addr == ADDR_W'(OFS_CTRL))
        rd_mux = DW'(NUM_SRC) << 2;
      else if (route_hit)
        rd_mux = DW'(route_q[route_idx]);
    end else begin
      if (bus_addr == ADDR_W'(OFS_ACK))
        rd_mux = pend_any[bus_cpu] ? DW'(pend_low[bus_cpu]) : DW'(ACK_NONE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_router_2lvl_chk.sv
module irq_router_2lvl_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  localparam int IW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_lvl,
  input logic               bus_rd,
  input logic               bus_win,
  input logic [CPU_W-1:0]   bus_cpu,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_rdata,
  input logic               bus_rvalid,
  input logic [NUM_CPU-1:0] cpu_irq
);
  logic [NUM_SRC-1:0] src_d;
  logic               ack_rd_d;
  logic [CPU_W-1:0]   unused_cpu;
  assign unused_cpu = bus_cpu;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_d    <= '0;
      ack_rd_d <= 1'b0;
    end else begin
      src_d    <= src_lvl;
      ack_rd_d <= bus_rd && bus_win && (bus_addr == ADDR_W'(32'h044));
    end
  end

  // R1: read data valid exactly one cycle after the strobe
  assert_rvalid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  assert_rvalid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  // R1: control word carries the source count
  assert_ctrl_word_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_win && bus_addr == '0) |=> (bus_rdata == 32'(NUM_SRC) << 2));

  // R2/R8: with every line low, all outputs are low one edge later
  assert_quiet_lines_R2: assert property (@(posedge clk) disable iff (rst)
    (src_lvl == '0) |=> (cpu_irq == '0));

  // R9: acknowledge is 1023 or a source whose line was high
  assert_ack_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && ack_rd_d) |->
      (bus_rdata[31:10] == '0) &&
      ((bus_rdata[9:0] == 10'd1023) ||
       ((bus_rdata[9:0] < 10'(NUM_SRC)) && src_d[bus_rdata[IW-1:0]])));
endmodule

bind irq_router_2lvl irq_router_2lvl_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_CPU (NUM_CPU),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_lvl    (src_lvl),
  .bus_rd     (bus_rd),
  .bus_win    (bus_win),
  .bus_cpu    (bus_cpu),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .cpu_irq    (cpu_irq)
);

// File: tb/tb_irq_router_2lvl.sv
`timescale 1ns/1ps
module tb_irq_router_2lvl;
  localparam int NS = 64;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_lvl = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_win = 1'b0;
  logic [1:0]    bus_cpu = '0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NC-1:0] cpu_irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  irq_router_2lvl dut (
    .clk(clk), .rst(rst), .src_lvl(src_lvl),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_win(bus_win), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic win, input logic [1:0] cpu, input logic [11:0] a,
                    input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_win = win; bus_cpu = cpu; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic win, input logic [1:0] cpu, input logic [11:0] a,
                    output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_win = win; bus_cpu = cpu; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    chk("R1 rvalid", {31'b0, bus_rvalid}, 32'd1);
  endtask

  task automatic line(input int s, input logic v);
    @(negedge clk);
    src_lvl[s] = v;
  endtask

  // register helpers
  task automatic en_on(input int s);  wr(1'b0, 2'd0, 12'h030, 32'(s)); endtask
  task automatic en_off(input int s); wr(1'b0, 2'd0, 12'h034, 32'(s)); endtask
  task automatic msk(input int c, input int s);   wr(1'b1, 2'(c), 12'h048, 32'(s)); endtask
  task automatic unmsk(input int c, input int s); wr(1'b1, 2'(c), 12'h04C, 32'(s)); endtask
  task automatic route(input int s, input logic [3:0] m);
    wr(1'b0, 2'd0, 12'(32'h100 + 4 * s), {28'b0, m});
  endtask
  task automatic ack(input int c, output logic [31:0] d);
    rd(1'b1, 2'(c), 12'h044, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R2 cpu_irq after reset", {28'b0, cpu_irq}, 32'h0);
    rd(1'b0, 2'd0, 12'h100 + 12'd4 * 12'd40, d);
    chk("R2 routing field reset", d, 32'h0);
    src_lvl = '1;
    step(); step();
    chk("R2 lines high but disabled", {28'b0, cpu_irq}, 32'h0);
    en_on(3); en_on(45);
    step();
    chk("R2 enabled but masked/unrouted", {28'b0, cpu_irq}, 32'h0);
    ack(0, d);
    chk("R9 ack none", d, 32'd1023);
    en_off(3); en_off(45);
    src_lvl = '0;
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    rd(1'b0, 2'd0, 12'h000, d);
    chk("R1 control word", d, 32'(NS) << 2);
  endtask

  task automatic t_private();
    logic [31:0] d;
    line(5, 1'b1);
    en_on(5); step();
    chk("R5 masked after reset", {28'b0, cpu_irq}, 32'h0);
    unmsk(2, 5); step();
    chk("R5 unmask cpu2 only", {28'b0, cpu_irq}, 32'h4);
    ack(2, d);  chk("R9 ack cpu2", d, 32'd5);
    ack(0, d);  chk("R9 ack cpu0 none", d, 32'd1023);
    route(5, 4'hF); step();
    chk("R6 routing ignored for private", {28'b0, cpu_irq}, 32'h4);
    msk(2, 5); step();
    chk("R5 mask again", {28'b0, cpu_irq}, 32'h0);
    unmsk(2, 5); step();
    en_off(5); step();
    chk("R3 clear enable", {28'b0, cpu_irq}, 32'h0);
    wr(1'b0, 2'd0, 12'h030, 32'd69); step();
    chk("R3 out-of-range index ignored", {28'b0, cpu_irq}, 32'h0);
    route(5, 4'h0); msk(2, 5); line(5, 1'b0);
  endtask

  task automatic t_shared();
    logic [31:0] d;
    line(40, 1'b1);
    en_on(40); step();
    chk("R7 unrouted shared", {28'b0, cpu_irq}, 32'h0);
    route(40, 4'hA); step();
    chk("R7 routed cpu1+cpu3", {28'b0, cpu_irq}, 32'hA);
    rd(1'b0, 2'd0, 12'h100 + 12'd160, d);
    chk("R4 routing readback", d, 32'hA);
    msk(1, 40); step();
    chk("R7 mask ignored for shared", {28'b0, cpu_irq}, 32'hA);
    ack(3, d);  chk("R9 ack shared cpu3", d, 32'd40);
    route(40, 4'h0); step();
    chk("R4 routing cleared", {28'b0, cpu_irq}, 32'h0);
    en_off(40); line(40, 1'b0);
  endtask

  task automatic t_boundary();
    line(28, 1'b1); line(29, 1'b1);
    en_on(28); en_on(29);
    route(28, 4'hF); step();
    chk("R6 source 28 is private", {28'b0, cpu_irq}, 32'h0);
    route(29, 4'h8); step();
    chk("R7 source 29 is shared", {28'b0, cpu_irq}, 32'h8);
    unmsk(0, 28); step();
    chk("R6 source 28 unmask cpu0", {28'b0, cpu_irq}, 32'h9);
    en_off(28); en_off(29); route(28, 4'h0); route(29, 4'h0); msk(0, 28);
    line(28, 1'b0); line(29, 1'b0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    en_on(3); en_on(7); en_on(30);
    unmsk(0, 3); unmsk(0, 7); route(30, 4'h1);
    line(30, 1'b1); line(7, 1'b1); line(3, 1'b1);
    ack(0, d);  chk("R9 lowest first", d, 32'd3);
    ack(0, d);  chk("R9 read has no side effect", d, 32'd3);
    line(3, 1'b0);
    ack(0, d);  chk("R9 next after drop", d, 32'd7);
    line(7, 1'b0);
    ack(0, d);  chk("R9 shared last", d, 32'd30);
    line(30, 1'b0);
    ack(0, d);  chk("R9 none after all drop", d, 32'd1023);
    step();
    chk("R9 output low after drops", {28'b0, cpu_irq}, 32'h0);
    en_off(3); en_off(7); en_off(30); msk(0, 3); msk(0, 7); route(30, 4'h0);
  endtask

  task automatic t_timing();
    en_on(10); unmsk(1, 10); step();
    @(negedge clk); src_lvl[10] = 1'b1;
    #1 chk("R8 no change before edge", {28'b0, cpu_irq}, 32'h0);
    @(negedge clk);
    chk("R8 one edge later", {28'b0, cpu_irq}, 32'h2);
    src_lvl[10] = 1'b0;
    #1 chk("R8 held until edge", {28'b0, cpu_irq}, 32'h2);
    @(negedge clk);
    chk("R8 falls one edge later", {28'b0, cpu_irq}, 32'h0);
    en_off(10); msk(1, 10);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    t_reset();
    t_ctrl();
    t_private();
    t_shared();
    t_boundary();
    t_order();
    t_timing();
    step();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule